// File: doc/BRIEF.md
# Three-Lane Synchronous Serial Frame Receiver

This block receives frames from an external device that supplies its own serial clock (about 100 kHz) along with three data lanes. Each lane carries an independent bit in every clock period. The receiver runs on a much faster system clock and oversamples the serial clock. The serial clock and the lanes each pass through a multi-flop synchronizer. The receiver then waits for the serial clock to go low and captures all three lanes together on the following low-to-high transition. Sixteen such captures make up one 48-bit frame word. The word is presented with a single-cycle valid strobe and stays held until the next frame completes.

The low phase of the serial clock is guarded by a timeout window, counted in system clock cycles. If the rising transition does not arrive within the window, the receiver does three things: it drops the partial frame, raises a one-cycle error strobe, and waits for a fresh falling edge before it starts counting samples again. Lane count, samples per frame, synchronizer depth and the window length are all parameters.

Top module: `tsf_frame_rx`

## Requirements
- R1: A synchronous active-high reset clears the frame word to zero, holds both strobes low and discards any partially captured frame.
- R2: Sample k of a frame (k = 0..SAMPLES-1) is stored in frame word bits [LANES*k+LANES-1 : LANES*k], with lane i in bit LANES*k+i (lane 0 lowest).
- R3: Exactly one frame_valid pulse, one system cycle wide, is produced for every SAMPLES accepted rising transitions.
- R4: frame_word changes only in the cycle in which frame_valid is high; a timeout leaves it unchanged.
- R5: Lanes are sampled only at an accepted rising transition of the serial clock; changing the lanes while the serial clock is high has no effect on the frame word.
- R6: If the serial clock stays low for more than TIMEOUT_CYC system cycles after a falling transition, timeout_err pulses high for exactly one cycle. A low phase of exactly TIMEOUT_CYC cycles is accepted without error, and a clock stuck low produces only one pulse.
- R7: After a timeout the partial frame is discarded. A complete new frame then needs SAMPLES further accepted rising transitions, starting from the next falling transition.
- R8: frame_valid is high in the cycle after SYNC_STAGES+1 system clock edges following the final serial clock rise of a frame, and low one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock driven by the external device |
| ser_data | input | LANES (3) | Parallel data lanes, one bit per lane per period |
| frame_word | output | LANES*SAMPLES (48) | Most recently completed frame |
| frame_valid | output | 1 | One-cycle strobe when frame_word updates |
| timeout_err | output | 1 | One-cycle strobe when a low phase exceeds the window |

## Verification
The behaviour hardest to reach from the ports is the timeout boundary in the middle of a frame. Here the error must fire, and the discarded samples must not leak into the next frame. The stimulus reaches it by driving several normal periods, then stretching one low phase to exactly the window and, elsewhere, to one cycle beyond it. It then sends a full fresh frame, whose word and strobe count expose any leftover samples. A permanently low clock checks that the error strobe does not repeat, and a reset in mid-frame checks that the partial capture is dropped.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

   typedef enum logic [0:0] {
      RX_AWAIT_FALL = 1'b0,
      RX_AWAIT_RISE = 1'b1
   } rx_phase_e;

endpackage

// File: rtl/tsf_sync.sv
module tsf_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("tsf_sync: WIDTH must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("tsf_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[STAGES-2:0], async_in[b]};
      end

      assign sync_out[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/tsf_edge.sv
module tsf_edge (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic rise,
   output logic fall
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= level;
   end

   assign rise = level  & ~prev_q;
   assign fall = ~level &  prev_q;

endmodule

// File: rtl/tsf_window.sv
module tsf_window #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);

   localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("tsf_window: LIMIT must be at least 2");
   end

   logic [TW-1:0] count_q;

   assign expired = run && (count_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run)      count_q <= '0;
      else if (!expired)    count_q <= count_q + 1'b1;
   end

   // R6: the owner leaves the timed phase on expiry, so it cannot repeat
   a_r6_expire_once : assert property (@(posedge clk) disable iff (rst)
      expired |=> !expired);

endmodule

// File: rtl/tsf_assemble.sv
module tsf_assemble
   import tsf_pkg::*;
#(
   parameter int LANES   = 3,
   parameter int SAMPLES = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       rise,
   input  logic                       fall,
   input  logic [LANES-1:0]           lanes,
   input  logic                       expired,
   output logic                       timing,
   output logic [LANES*SAMPLES-1:0]   frame_word,
   output logic                       frame_valid,
   output logic                       timeout_err
);

   localparam int FW = LANES * SAMPLES;
   localparam int CW = $clog2(SAMPLES);
   localparam logic [CW-1:0] LAST_IDX = CW'(SAMPLES - 1);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("tsf_assemble: SAMPLES must be at least 2");
   end

   rx_phase_e      phase_q;
   logic [CW-1:0]  idx_q;
   logic [FW-1:0]  shift_q;
   logic [FW-1:0]  shift_nx;

   // newest sample enters at the top; after SAMPLES shifts sample 0 sits lowest
   if (LANES == FW) begin : g_single
      assign shift_nx = lanes;
   end else begin : g_shift
      assign shift_nx = {lanes, shift_q[FW-1:LANES]};
   end

   assign timing = (phase_q == RX_AWAIT_RISE);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q     <= RX_AWAIT_FALL;
         idx_q       <= '0;
         shift_q     <= '0;
         frame_word  <= '0;
         frame_valid <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         timeout_err <= 1'b0;
         unique case (phase_q)
            RX_AWAIT_FALL: begin
               if (fall) phase_q <= RX_AWAIT_RISE;
            end
            RX_AWAIT_RISE: begin
               if (rise) begin
                  shift_q <= shift_nx;
                  phase_q <= RX_AWAIT_FALL;
                  if (idx_q == LAST_IDX) begin
                     idx_q       <= '0;
                     frame_word  <= shift_nx;
                     frame_valid <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else if (expired) begin
                  idx_q       <= '0;
                  shift_q     <= '0;
                  timeout_err <= 1'b1;
                  phase_q     <= RX_AWAIT_FALL;
               end
            end
            default: phase_q <= RX_AWAIT_FALL;
         endcase
      end
   end

   // R3: completion strobe lasts one cycle
   a_r3_valid_single : assert property (@(posedge clk) disable iff (rst)
      frame_valid |=> !frame_valid);

   // R4: the held word moves only alongside the strobe
   a_r4_word_held : assert property (@(posedge clk) disable iff (rst)
      !frame_valid |-> $stable(frame_word));

   // R6: error strobe lasts one cycle
   a_r6_err_single : assert property (@(posedge clk) disable iff (rst)
      timeout_err |=> !timeout_err);

   // R7: an aborted frame can never complete in the same cycle
   a_r7_no_overlap : assert property (@(posedge clk) disable iff (rst)
      !(timeout_err && frame_valid));

   // R3: sample index stays inside the frame
   a_r3_index_range : assert property (@(posedge clk) disable iff (rst)
      idx_q <= LAST_IDX);

endmodule

// File: rtl/tsf_frame_rx.sv
module tsf_frame_rx #(
   parameter int LANES       = 3,
   parameter int SAMPLES     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       ser_clk,
   input  logic [LANES-1:0]           ser_data,
   output logic [LANES*SAMPLES-1:0]   frame_word,
   output logic                       frame_valid,
   output logic                       timeout_err
);

   localparam int SW = LANES + 1;

   if (LANES < 1) begin : g_bad_lanes
      $error("tsf_frame_rx: LANES must be at least 1");
   end

   logic [SW-1:0]    sync_bus;
   logic             clk_s;
   logic [LANES-1:0] lanes_s;
   logic             rise;
   logic             fall;
   logic             timing;
   logic             expired;

   // clock and lanes share one synchronizer so they stay aligned
   tsf_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in ({ser_data, ser_clk}),
      .sync_out (sync_bus)
   );

   assign clk_s   = sync_bus[0];
   assign lanes_s = sync_bus[SW-1:1];

   tsf_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (clk_s),
      .rise  (rise),
      .fall  (fall)
   );

   tsf_window #(.LIMIT(TIMEOUT_CYC)) u_window (
      .clk     (clk),
      .rst     (rst),
      .run     (timing),
      .expired (expired)
   );

   tsf_assemble #(.LANES(LANES), .SAMPLES(SAMPLES)) u_asm (
      .clk         (clk),
      .rst         (rst),
      .rise        (rise),
      .fall        (fall),
      .lanes       (lanes_s),
      .expired     (expired),
      .timing      (timing),
      .frame_word  (frame_word),
      .frame_valid (frame_valid),
      .timeout_err (timeout_err)
   );

endmodule

// File: tb/tsf_frame_rx_test.sv
module tsf_frame_rx_test;

   localparam int LANES   = 3;
   localparam int SAMPLES = 16;
   localparam int STAGES  = 2;
   localparam int WIN     = 40;
   localparam int FW      = LANES * SAMPLES;
   localparam int HIGH_LEN = 6;
   localparam int NVEC    = 6;

   // {pattern, low phase length}
   localparam logic [55:0] VECS [NVEC] = '{
      {48'h000000000000, 8'd5},
      {48'hFFFFFFFFFFFF, 8'd40},
      {48'h924924924924, 8'd3},
      {48'h249249249249, 8'd7},
      {48'hB5C3A1E0F792, 8'd12},
      {48'h0123456789AB, 8'd40}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ser_clk = 1'b1;
   logic [2:0]    ser_data = '0;
   logic [FW-1:0] frame_word;
   logic          frame_valid;
   logic          timeout_err;

   int nchk  = 0;
   int nfail = 0;
   int nvalid = 0;
   int nerr   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tsf_frame_rx #(
      .LANES(LANES), .SAMPLES(SAMPLES), .SYNC_STAGES(STAGES), .TIMEOUT_CYC(WIN)
   ) uut (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
      .frame_word(frame_word), .frame_valid(frame_valid), .timeout_err(timeout_err)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (frame_valid) nvalid++;
         if (timeout_err) nerr++;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic period(input logic [2:0] d, input int low_len, input bit probe);
      @(negedge clk);
      ser_clk  = 1'b0;
      ser_data = d;
      repeat (low_len) @(negedge clk);
      ser_clk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (probe) chk("R8 valid early", 64'(frame_valid), 64'd0);
      ser_data = ~d;   // R5: lane noise during the high phase
      @(negedge clk);
      if (probe) chk("R8 valid on time", 64'(frame_valid), 64'd1);
      repeat (HIGH_LEN - 3) @(negedge clk);
   endtask

   task automatic frame(input logic [FW-1:0] pat, input int low_len, input bit probe);
      for (int k = 0; k < SAMPLES; k++)
         period(pat[LANES*k +: LANES], low_len, probe && (k == SAMPLES - 1));
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int v0, e0;
      logic [FW-1:0] held;

      repeat (4) @(negedge clk);
      chk("R1 word", 64'(frame_word), 64'd0);
      chk("R1 valid", 64'(frame_valid), 64'd0);
      chk("R1 err", 64'(timeout_err), 64'd0);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // table walk: R2 packing, R3 one strobe, R5 noise ignored, R6 window edge
      for (int i = 0; i < NVEC; i++) begin
         v0 = nvalid; e0 = nerr;
         frame(VECS[i][55:8], int'(VECS[i][7:0]), 1'b0);
         chk("R2 R5 word", 64'(frame_word), 64'(VECS[i][55:8]));
         chk("R3 strobes", 64'(nvalid - v0), 64'd1);
         chk("R6 no err", 64'(nerr - e0), 64'd0);
      end

      // R8 latency of the final rise
      v0 = nvalid;
      frame(48'hA5A5A5A5A5A5, 6, 1'b1);
      chk("R8 word", 64'(frame_word), 64'hA5A5A5A5A5A5);
      chk("R8 strobes", 64'(nvalid - v0), 64'd1);

      // R6 R7 R4: abort mid-frame with a low phase one cycle over the window
      held = frame_word;
      v0 = nvalid; e0 = nerr;
      for (int k = 0; k < 5; k++) period(3'b101, 5, 1'b0);
      period(3'b011, WIN + 1, 1'b0);
      repeat (4) @(negedge clk);
      chk("R6 err pulse", 64'(nerr - e0), 64'd1);
      chk("R4 word kept", 64'(frame_word), 64'(held));
      chk("R7 no strobe", 64'(nvalid - v0), 64'd0);
      frame(48'h3C3C0F0F5A5A, 6, 1'b0);
      chk("R7 fresh word", 64'(frame_word), 64'h3C3C0F0F5A5A);
      chk("R7 fresh strobe", 64'(nvalid - v0), 64'd1);

      // R6: clock stuck low gives a single error
      e0 = nerr;
      @(negedge clk);
      ser_clk = 1'b0;
      repeat (WIN * 5) @(negedge clk);
      chk("R6 stuck single", 64'(nerr - e0), 64'd1);
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
      v0 = nvalid;
      frame(48'h112233445566, 8, 1'b0);
      chk("R7 after stuck", 64'(frame_word), 64'h112233445566);
      chk("R7 after stuck strobe", 64'(nvalid - v0), 64'd1);

      // R1: reset during a partial frame
      for (int k = 0; k < 7; k++) period(3'b111, 5, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 mid word", 64'(frame_word), 64'd0);
      chk("R1 mid valid", 64'(frame_valid), 64'd0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      v0 = nvalid;
      frame(48'h7E7E00FF1234, 5, 1'b0);
      chk("R1 restart word", 64'(frame_word), 64'h7E7E00FF1234);
      chk("R1 restart strobe", 64'(nvalid - v0), 64'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule